// File: doc/BRIEF.md
# Video Fetch Address Sequencer

This block produces the memory address for every video RAM read of a raster display, one address per video slot. A scanline always has 64 fetch slots. The first 40 slots carry displayed bytes. The other 24 fall in horizontal blank. They are still issued and simply run on into the bytes that follow. A frame has 312 scanlines, and fetching never pauses, not even in vertical blank.

Two addressing schemes are supported. In character mode, one 40-byte row is fetched on 8 consecutive scanlines, starting from 0xBB80. In bitmap mode, each scanline fetches its own 40 bytes, starting from 0xA000. From scanline 200 to the end of the frame, character addressing is forced whatever the mode input says. This part restarts at 0xBFE0, so the addresses climb past 0xBFFF into the region at and above 0xC000.

The block flags displayed fetches, blank fetches and fetches that land at or above 0xC000. It also exposes its line and column position so that a downstream bus observer can tell which reads carry meaningful data.

Top module: `vid_fetch_seq`

## Requirements
- R1: While rst_n is low, col_cnt and line_cnt are 0 and fetch_addr is 0xBB80 when gfx_mode is 0 or 0xA000 when gfx_mode is 1.
- R2: Each clock with slot_en high advances col_cnt by one. After column 63 the count returns to 0 and line_cnt increments. With slot_en low, both counts hold.
- R3: display_valid is 1 exactly when col_cnt < 40 and line_cnt < 200. blank is its complement.
- R4: With gfx_mode 0 and line_cnt < 200, fetch_addr = 0xBB80 + 40*(line_cnt/8) + col_cnt. Columns 40 to 63 therefore read into the next character row.
- R5: With gfx_mode 1 and line_cnt < 200, fetch_addr = 0xA000 + 40*line_cnt + col_cnt.
- R6: For line_cnt >= 200, gfx_mode has no effect and fetch_addr = 0xBFE0 + 40*((line_cnt-200)/8) + col_cnt.
- R7: rom_space is 1 exactly when fetch_addr >= 0xC000.
- R8: After the last slot of line 311, line_cnt and col_cnt return to 0 and the address restarts at the frame base of the current mode.
- R9: On lines 200 to 207, columns 0 to 31 address 0xBFE0 to 0xBFFF and columns 32 to 63 address 0xC000 to 0xC01F. From line 208 to the end of the frame, every fetch has rom_space set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | 1 | One video fetch slot completes this cycle |
| gfx_mode | input | 1 | 1 selects bitmap addressing, 0 selects character addressing |
| fetch_addr | output | 16 | Address of the current fetch |
| display_valid | output | 1 | Current fetch supplies a displayed byte |
| blank | output | 1 | Current fetch falls in horizontal or vertical blank |
| rom_space | output | 1 | Current address is at or above 0xC000 |
| line_cnt | output | 9 | Current scanline, 0 to 311 |
| col_cnt | output | 6 | Current fetch slot within the line, 0 to 63 |

## Verification
The hardest situations to reach are deep in the frame: the line-199 to line-200 handoff, the crossing at 0xC000 inside line 200, and the wrap at line 311. Each of them needs about 13,000 to 20,000 slots to get there. The stimulus first runs a full frame with slots on every cycle, so these points come up early in the run. It then runs with random slot gaps and random mode toggles, so a second pass crosses the same boundaries while the mode changes mid-line and while slots stall. Mode toggles during vertical blank show whether the forced character addressing really ignores the mode input.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int          FETCH_PER_LINE = 64;
  localparam int          SHOWN_COLS     = 40;
  localparam int          SHOWN_LINES    = 200;
  localparam int          FRAME_LINES    = 312;
  localparam int          ROW_LINES      = 8;
  localparam int          ADDR_W         = 16;
  localparam logic [15:0] TEXT_BASE      = 16'hBB80;
  localparam logic [15:0] BITMAP_BASE    = 16'hA000;
  localparam logic [15:0] VBL_BASE       = 16'hBFE0;
  localparam logic [15:0] ROM_START      = 16'hC000;

  typedef enum logic [1:0] {
    SRC_TEXT   = 2'd0,
    SRC_BITMAP = 2'd1,
    SRC_VBLANK = 2'd2
  } src_e;
endpackage

// File: rtl/vfs_pos_ctr.sv
module vfs_pos_ctr #(
  parameter int FETCH_PER_LINE = 64,
  parameter int FRAME_LINES    = 312,
  parameter int ROW_LINES      = 8,
  localparam int COL_W  = $clog2(FETCH_PER_LINE),
  localparam int LINE_W = $clog2(FRAME_LINES),
  localparam int PH_W   = (ROW_LINES > 1) ? $clog2(ROW_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] line,
  output logic              line_end,
  output logic              row_end,
  output logic              frame_end
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(FETCH_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(ROW_LINES - 1);

  logic [PH_W-1:0] phase;

  function automatic logic [COL_W-1:0] col_next(logic [COL_W-1:0] c);
    return (c == LAST_COL) ? '0 : c + 1'b1;
  endfunction

  assign line_end  = slot_en && (col == LAST_COL);
  assign frame_end = line_end && (line == LAST_LINE);
  assign row_end   = line_end && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col   <= '0;
      line  <= '0;
      phase <= '0;
    end else if (slot_en) begin
      col <= col_next(col);
      if (line_end) begin
        line  <= frame_end ? '0 : line + 1'b1;
        phase <= (frame_end || row_end) ? '0 : phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfs_base_trk.sv
module vfs_base_trk #(
  parameter int          ADDR_W      = 16,
  parameter int          STRIDE      = 40,
  parameter logic [15:0] TEXT_BASE   = 16'hBB80,
  parameter logic [15:0] BITMAP_BASE = 16'hA000,
  parameter logic [15:0] VBL_BASE    = 16'hBFE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              row_end,
  input  logic              frame_end,
  input  logic              last_shown,
  output logic [ADDR_W-1:0] text_base,
  output logic [ADDR_W-1:0] bitmap_base
);
  function automatic logic [ADDR_W-1:0] add_stride(logic [ADDR_W-1:0] b);
    return b + ADDR_W'(STRIDE);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      text_base   <= ADDR_W'(TEXT_BASE);
      bitmap_base <= ADDR_W'(BITMAP_BASE);
    end else if (line_end) begin
      if (frame_end)       text_base <= ADDR_W'(TEXT_BASE);
      else if (last_shown) text_base <= ADDR_W'(VBL_BASE);
      else if (row_end)    text_base <= add_stride(text_base);
      bitmap_base <= frame_end ? ADDR_W'(BITMAP_BASE) : add_stride(bitmap_base);
    end
  end
endmodule

// File: rtl/vfs_addr_gen.sv
module vfs_addr_gen
  import vfs_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          COL_W       = 6,
  parameter int          LINE_W      = 9,
  parameter int          SHOWN_COLS  = 40,
  parameter int          SHOWN_LINES = 200,
  parameter logic [15:0] ROM_START   = 16'hC000
) (
  input  logic [COL_W-1:0]  col,
  input  logic [LINE_W-1:0] line,
  input  logic              gfx_mode,
  input  logic [ADDR_W-1:0] text_base,
  input  logic [ADDR_W-1:0] bitmap_base,
  output logic [ADDR_W-1:0] addr,
  output logic              display_valid,
  output logic              blank,
  output logic              rom_space,
  output logic              forced_text,
  output src_e              src
);
  always_comb begin
    forced_text = (line >= LINE_W'(SHOWN_LINES));
    if (forced_text)   src = SRC_VBLANK;
    else if (gfx_mode) src = SRC_BITMAP;
    else               src = SRC_TEXT;
    addr          = ((src == SRC_BITMAP) ? bitmap_base : text_base) + ADDR_W'(col);
    display_valid = !forced_text && (col < COL_W'(SHOWN_COLS));
    blank         = !display_valid;
    rom_space     = (addr >= ADDR_W'(ROM_START));
  end
endmodule

// File: rtl/vid_fetch_seq.sv
module vid_fetch_seq
  import vfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slot_en,
  input  logic        gfx_mode,
  output logic [15:0] fetch_addr,
  output logic        display_valid,
  output logic        blank,
  output logic        rom_space,
  output logic [8:0]  line_cnt,
  output logic [5:0]  col_cnt
);
  localparam int COL_W  = $clog2(FETCH_PER_LINE);
  localparam int LINE_W = $clog2(FRAME_LINES);

  logic              line_end;
  logic              row_end;
  logic              frame_end;
  logic              last_shown;
  logic              forced_text;
  logic [ADDR_W-1:0] text_base;
  logic [ADDR_W-1:0] bitmap_base;
  src_e              fetch_src;

  vfs_pos_ctr #(
    .FETCH_PER_LINE(FETCH_PER_LINE),
    .FRAME_LINES   (FRAME_LINES),
    .ROW_LINES     (ROW_LINES)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_en  (slot_en),
    .col      (col_cnt),
    .line     (line_cnt),
    .line_end (line_end),
    .row_end  (row_end),
    .frame_end(frame_end)
  );

  assign last_shown = (line_cnt == LINE_W'(SHOWN_LINES - 1));

  vfs_base_trk #(
    .ADDR_W     (ADDR_W),
    .STRIDE     (SHOWN_COLS),
    .TEXT_BASE  (TEXT_BASE),
    .BITMAP_BASE(BITMAP_BASE),
    .VBL_BASE   (VBL_BASE)
  ) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .row_end    (row_end),
    .frame_end  (frame_end),
    .last_shown (last_shown),
    .text_base  (text_base),
    .bitmap_base(bitmap_base)
  );

  vfs_addr_gen #(
    .ADDR_W     (ADDR_W),
    .COL_W      (COL_W),
    .LINE_W     (LINE_W),
    .SHOWN_COLS (SHOWN_COLS),
    .SHOWN_LINES(SHOWN_LINES),
    .ROM_START  (ROM_START)
  ) u_addr (
    .col          (col_cnt),
    .line         (line_cnt),
    .gfx_mode     (gfx_mode),
    .text_base    (text_base),
    .bitmap_base  (bitmap_base),
    .addr         (fetch_addr),
    .display_valid(display_valid),
    .blank        (blank),
    .rom_space    (rom_space),
    .forced_text  (forced_text),
    .src          (fetch_src)
  );
endmodule

// File: rtl/vfs_seq_chk.sv
module vfs_seq_chk
  import vfs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        slot_en,
  input logic [15:0] fetch_addr,
  input logic        display_valid,
  input logic        rom_space,
  input logic [8:0]  line_cnt,
  input logic [5:0]  col_cnt,
  input logic        line_end,
  input logic        frame_end,
  input logic        forced_text
);
  localparam logic [5:0] LAST_COL  = 6'(FETCH_PER_LINE - 1);
  localparam logic [8:0] ALL_ROM   = 9'(SHOWN_LINES + ROW_LINES);

  // R2
  col_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en && col_cnt != LAST_COL |=> col_cnt == $past(col_cnt) + 6'd1);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> $stable(col_cnt) && $stable(line_cnt));

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !frame_end |=> col_cnt == 6'd0 && line_cnt == $past(line_cnt) + 9'd1);

  // R8
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> line_cnt == 9'd0 && col_cnt == 6'd0);

  // R3
  valid_not_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    display_valid |-> !rom_space && !forced_text);

  // R6
  forced_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forced_text |-> fetch_addr >= VBL_BASE);

  // R9
  late_vbl_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt >= ALL_ROM |-> rom_space);
endmodule

bind vid_fetch_seq vfs_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_en      (slot_en),
  .fetch_addr   (fetch_addr),
  .display_valid(display_valid),
  .rom_space    (rom_space),
  .line_cnt     (line_cnt),
  .col_cnt      (col_cnt),
  .line_end     (line_end),
  .frame_end    (frame_end),
  .forced_text  (forced_text)
);

// File: tb/sim_vid_fetch_seq.sv
`timescale 1ns/1ps
module sim_vid_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_en = 1'b0;
  logic        gfx_mode = 1'b0;
  logic [15:0] fetch_addr;
  logic        display_valid, blank, rom_space;
  logic [8:0]  line_cnt;
  logic [5:0]  col_cnt;

  int n_run = 0;
  int n_fail = 0;
  int m_line = 0;
  int m_col = 0;
  int frames = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vid_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .gfx_mode(gfx_mode),
    .fetch_addr(fetch_addr), .display_valid(display_valid), .blank(blank),
    .rom_space(rom_space), .line_cnt(line_cnt), .col_cnt(col_cnt)
  );

  function automatic int exp_addr(int ln, int c, bit g);
    if (ln >= 200) return 'hBFE0 + ((ln - 200) / 8) * 40 + c;
    if (g)         return 'hA000 + ln * 40 + c;
    return 'hBB80 + (ln / 8) * 40 + c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s line=%0d col=%0d actual=%0h expected=%0h", req, m_line, m_col, act, exp);
    end
  endtask

  task automatic check_all();
    int ea;
    string areq;
    ea = exp_addr(m_line, m_col, gfx_mode);
    areq = (m_line >= 200) ? "R6" : (gfx_mode ? "R5" : "R4");
    chk(areq, 32'(fetch_addr), 32'(ea));
    chk("R3 valid", 32'(display_valid), 32'(m_line < 200 && m_col < 40));
    chk("R3 blank", 32'(blank), 32'(!(m_line < 200 && m_col < 40)));
    chk("R7", 32'(rom_space), 32'(ea >= 'hC000));
    chk("R2 line", 32'(line_cnt), 32'(m_line));
    chk("R2 col", 32'(col_cnt), 32'(m_col));
    if (m_line >= 200 && m_line <= 207) begin
      if (m_col == 0)  chk("R9 first", 32'(fetch_addr), 32'h0000BFE0);
      if (m_col == 31) chk("R9 below", 32'(rom_space), 32'd0);
      if (m_col == 32) chk("R9 cross", 32'(fetch_addr), 32'h0000C000);
    end
    if (m_line >= 208) chk("R9 late", 32'(rom_space), 32'd1);
    if (frames > 0 && m_line == 0 && m_col == 0)
      chk("R8 wrap", 32'(fetch_addr), gfx_mode ? 32'h0000A000 : 32'h0000BB80);
  endtask

  task automatic step(bit en, bit rnd_mode);
    @(negedge clk);
    check_all();
    slot_en = en;
    if (rnd_mode && ($urandom % 16) == 0) gfx_mode = ~gfx_mode;
    if (en) begin
      if (m_col == 63) begin
        m_col = 0;
        if (m_line == 311) begin m_line = 0; frames++; end
        else m_line++;
      end else m_col++;
    end
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    slot_en = 1'b0;
    gfx_mode = mode;
    m_line = 0;
    m_col = 0;
    @(negedge clk);
    chk("R1 addr", 32'(fetch_addr), mode ? 32'h0000A000 : 32'h0000BB80);
    chk("R1 line", 32'(line_cnt), 32'd0);
    chk("R1 col", 32'(col_cnt), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset(1'b0);
    for (int i = 0; i < 312 * 64 + 20; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 45000; i++) step(($urandom % 4) != 0, 1'b1);
    do_reset(1'b1);
    frames = 0;
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule